// File: doc/BRIEF.md
# Tiled Local Field Engine

This block forms the local field vector of a fully coupled Ising-style solver: every field entry is the dot product of one row of a dense, signed coupling matrix with the spin amplitude vector, plus a per-spin bias. One engine instance owns one slice of the rows. The row count of that slice is the problem size divided by a partition parameter, and a block index parameter places the slice within the full field.

The work runs as a grid of tiles. In each cycle a multiply-accumulate array of PR rows by PC columns takes one PR×PC coupling tile and one PC-wide slice of the amplitude vector. Both come from synchronous memories outside the block that the engine addresses through one shared read enable. All column tiles of one row tile go through the array before the engine moves on to the next row tile. On the last column tile the bias is added, and the PR finished entries leave on a valid/ready stream. A start pulse launches one complete pass and a done pulse closes it. Backpressure on the result stream freezes both the addressing and the accumulators.

Top module: `lf_engine`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid` and `rd_en` are all low.
- R2: Let lr be the local row rt*PR+r. Result element r of row tile rt is carried in `out_data[r*32 +: 32]`. It equals the sum over every column c of J[lr][c]*x[c], plus z[lr], in 32-bit signed arithmetic. J element (r,c) of a tile sits at bits (r*PC+c)*16 of the J word. Element c of the x word sits at bits c*16. Bias r of the z word sits at bits r*32.
- R3: After each column tile the accumulator saturates to the 32-bit signed range, clamping at 2147483647 and at -2147483648. On the last tile the bias enters the same saturating sum.
- R4: Reads are issued in order. The column tile runs fastest, then the row tile. For read k, `j_addr` is k, `x_addr` is k mod (N/PC) and `z_addr` is k div (N/PC). Each result carries `out_row` = (BLK_ID*(N/PB)/PR + rt)*PR, and row tiles leave in ascending order.
- R5: The bias enters each field entry exactly once. With an all-zero J the results equal z.
- R6: Accumulators clear on the first column tile of every row tile, so neither earlier rows nor earlier passes leak into a result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` and `out_row` hold their values, and `rd_en` is low. No result is lost or duplicated.
- R8: `done` is high for exactly one cycle, in the cycle right after the final row tile is accepted. `busy` is low in that cycle.
- R9: A `start` pulse while `busy` is high has no effect on the pass in progress.
- R10: One pass delivers exactly (N/PB)/PR results and issues exactly (N/PB)/PR*(N/PC) reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one pass (ignored while busy) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the final result is accepted |
| rd_en | output | 1 | Read enable shared by the J, x and z memories |
| j_addr | output | J_AW | Coupling tile address, rowTile*(N/PC)+colTile |
| j_rdata | input | PR*PC*16 | Coupling tile, returned one cycle after rd_en |
| x_addr | output | X_AW | Amplitude slice address (column tile) |
| x_rdata | input | PC*16 | Amplitude slice |
| z_addr | output | Z_AW | Bias word address (row tile) |
| z_rdata | input | PR*32 | Bias entries of the row tile |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_row | output | RW | Global index of the first field entry in the result |
| out_data | output | PR*32 | PR field entries |

## Verification
The bench builds the engine with N=8, PR=2, PC=4, PB=2 and BLK_ID=1. That gives a non-square tile, two column tiles per row tile and a nonzero row offset. With two column tiles per row tile, accumulation across tiles and the clear at each row boundary both show in the results. The nonzero block index makes the offset show in `out_row`. The memories are tiny, so extreme operands can drive every accumulator into both saturation limits in a few cycles. Irregular ready patterns can then test stalls in every pipeline position.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int VAL_W = 16;
    localparam int ACC_W = 32;
    localparam int SUM_W = 48;

    localparam logic signed [SUM_W-1:0] ACC_MAX = 48'sd2147483647;
    localparam logic signed [SUM_W-1:0] ACC_MIN = -48'sd2147483648;

    function automatic logic [ACC_W-1:0] sat_acc(input logic signed [SUM_W-1:0] v);
        if (v > ACC_MAX)      return 32'h7FFF_FFFF;
        else if (v < ACC_MIN) return 32'h8000_0000;
        else                  return v[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/lf_seq.sv
module lf_seq #(
    parameter int RT = 4,
    parameter int CT = 4,
    localparam int RTW = (RT > 1) ? $clog2(RT) : 1,
    localparam int CTW = (CT > 1) ? $clog2(CT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           stall,
    input  logic           last_accept,
    output logic           busy,
    output logic           done,
    output logic           issue,
    output logic [RTW-1:0] rt_idx,
    output logic [CTW-1:0] ct_idx,
    output logic           pend,
    output logic           pend_first,
    output logic           pend_last,
    output logic [RTW-1:0] pend_rt
);
    typedef struct packed {
        logic           busy;
        logic           issued_all;
        logic [RTW-1:0] rt;
        logic [CTW-1:0] ct;
        logic           pend;
        logic           pend_first;
        logic           pend_last;
        logic [RTW-1:0] pend_rt;
        logic           done;
    } seq_t;

    seq_t s_d, s_q;
    logic issue_c;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        issue_c = s_q.busy && !s_q.issued_all && !stall;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy       = 1'b1;
                s_d.issued_all = 1'b0;
                s_d.rt         = '0;
                s_d.ct         = '0;
                s_d.pend       = 1'b0;
            end
        end else begin
            // pending tile is consumed in every cycle without stall
            if (!stall) s_d.pend = issue_c;
            if (issue_c) begin
                s_d.pend_first = (s_q.ct == '0);
                s_d.pend_last  = (s_q.ct == CTW'(CT - 1));
                s_d.pend_rt    = s_q.rt;
                if (s_q.ct == CTW'(CT - 1)) begin
                    s_d.ct = '0;
                    if (s_q.rt == RTW'(RT - 1)) s_d.issued_all = 1'b1;
                    else                        s_d.rt = s_q.rt + 1'b1;
                end else begin
                    s_d.ct = s_q.ct + 1'b1;
                end
            end
            if (last_accept) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign issue      = issue_c;
    assign rt_idx     = s_q.rt;
    assign ct_idx     = s_q.ct;
    assign pend       = s_q.pend;
    assign pend_first = s_q.pend_first;
    assign pend_last  = s_q.pend_last;
    assign pend_rt    = s_q.pend_rt;
endmodule

// File: rtl/lf_mac_row.sv
module lf_mac_row
    import lf_pkg::*;
#(
    parameter int PC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  consume,
    input  logic                  first,
    input  logic                  last,
    input  logic [PC*VAL_W-1:0]   j_row,
    input  logic [PC*VAL_W-1:0]   x_vec,
    input  logic [ACC_W-1:0]      bias,
    output logic [ACC_W-1:0]      acc
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = first ? '0 : {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        for (int c = 0; c < PC; c++) begin
            logic signed [2*VAL_W-1:0] prod;
            prod = $signed(j_row[c*VAL_W +: VAL_W]) * $signed(x_vec[c*VAL_W +: VAL_W]);
            sum  = sum + {{(SUM_W-2*VAL_W){prod[2*VAL_W-1]}}, prod};
        end
        if (last) sum = sum + {{(SUM_W-ACC_W){bias[ACC_W-1]}}, bias};
        acc_d = consume ? sat_acc(sum) : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/lf_engine.sv
module lf_engine
    import lf_pkg::*;
#(
    parameter int N      = 16,
    parameter int PR     = 2,
    parameter int PC     = 4,
    parameter int PB     = 2,
    parameter int BLK_ID = 0,
    localparam int NB      = N / PB,
    localparam int RT      = NB / PR,
    localparam int CT      = N / PC,
    localparam int J_DEPTH = RT * CT,
    localparam int J_AW    = (J_DEPTH > 1) ? $clog2(J_DEPTH) : 1,
    localparam int X_AW    = (CT > 1) ? $clog2(CT) : 1,
    localparam int Z_AW    = (RT > 1) ? $clog2(RT) : 1,
    localparam int RW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   rd_en,
    output logic [J_AW-1:0]        j_addr,
    input  logic [PR*PC*VAL_W-1:0] j_rdata,
    output logic [X_AW-1:0]        x_addr,
    input  logic [PC*VAL_W-1:0]    x_rdata,
    output logic [Z_AW-1:0]        z_addr,
    input  logic [PR*ACC_W-1:0]    z_rdata,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [RW-1:0]          out_row,
    output logic [PR*ACC_W-1:0]    out_data
);
    typedef struct packed {
        logic           valid;
        logic [Z_AW-1:0] rt;
    } out_t;

    out_t o_d, o_q;

    logic            stall, consume, last_accept;
    logic            issue, pend, pend_first, pend_last;
    logic [Z_AW-1:0] rt_idx, pend_rt;
    logic [X_AW-1:0] ct_idx;

    assign stall       = o_q.valid && !out_ready;
    assign consume     = pend && !stall;
    assign last_accept = o_q.valid && out_ready && (o_q.rt == Z_AW'(RT - 1));

    lf_seq #(.RT(RT), .CT(CT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stall       (stall),
        .last_accept (last_accept),
        .busy        (busy),
        .done        (done),
        .issue       (issue),
        .rt_idx      (rt_idx),
        .ct_idx      (ct_idx),
        .pend        (pend),
        .pend_first  (pend_first),
        .pend_last   (pend_last),
        .pend_rt     (pend_rt)
    );

    assign rd_en  = issue;
    assign j_addr = J_AW'(int'(rt_idx) * CT + int'(ct_idx));
    assign x_addr = ct_idx;
    assign z_addr = rt_idx;

    for (genvar r = 0; r < PR; r++) begin : g_row
        lf_mac_row #(.PC(PC)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .consume (consume),
            .first   (pend_first),
            .last    (pend_last),
            .j_row   (j_rdata[r*PC*VAL_W +: PC*VAL_W]),
            .x_vec   (x_rdata),
            .bias    (z_rdata[r*ACC_W +: ACC_W]),
            .acc     (out_data[r*ACC_W +: ACC_W])
        );
    end

    always_comb begin
        o_d = o_q;
        if (consume && pend_last) begin
            o_d.valid = 1'b1;
            o_d.rt    = pend_rt;
        end else if (out_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_row   = RW'((BLK_ID * RT + int'(o_q.rt)) * PR);
endmodule

// File: rtl/lf_engine_chk.sv
module lf_engine_chk #(
    parameter int JAW   = 4,
    parameter int DEPTH = 16,
    parameter int RWW   = 4,
    parameter int DW    = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           rd_en,
    input logic [JAW-1:0] j_addr,
    input logic           out_valid,
    input logic           out_ready,
    input logic [RWW-1:0] out_row,
    input logic [DW-1:0]  out_data
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_row)); // R7
    AST_STALL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !rd_en); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid); // R8
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> int'(j_addr) < DEPTH); // R4
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy); // R9
    AST_START_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !out_valid |=> busy); // R9
endmodule

bind lf_engine lf_engine_chk #(
    .JAW(J_AW), .DEPTH(J_DEPTH), .RWW(RW), .DW(PR*32)
) u_chk (.*);

// File: tb/tb_lf_engine.sv
module tb_lf_engine;
    localparam int N = 8, PR = 2, PC = 4, PB = 2, BLK = 1;
    localparam int NB = N / PB, RT = NB / PR, CT = N / PC, DEPTH = RT * CT;
    localparam int JAW = $clog2(DEPTH), XAW = (CT > 1) ? $clog2(CT) : 1;
    localparam int ZAW = (RT > 1) ? $clog2(RT) : 1, RW = $clog2(N);

    logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
    logic busy, done, rd_en, out_valid;
    logic [JAW-1:0] j_addr;
    logic [XAW-1:0] x_addr;
    logic [ZAW-1:0] z_addr;
    logic [PR*PC*16-1:0] j_rdata;
    logic [PC*16-1:0] x_rdata;
    logic [PR*32-1:0] z_rdata, out_data;
    logic [RW-1:0] out_row;

    always #10 clk = ~clk;

    lf_engine #(.N(N), .PR(PR), .PC(PC), .PB(PB), .BLK_ID(BLK)) dut (.*);

    logic [PR*PC*16-1:0] jmem [DEPTH];
    logic [PC*16-1:0]    xmem [CT];
    logic [PR*32-1:0]    zmem [RT];
    int jm [NB][N];
    int xm [N];
    int zm [NB];

    always @(posedge clk) if (rd_en) begin
        j_rdata <= jmem[j_addr];
        x_rdata <= xmem[x_addr];
        z_rdata <= zmem[z_addr];
    end

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // capture state
    logic [PR*32-1:0] cap_data [16];
    int cap_row [16];
    int cap_n = 0, done_cnt = 0, iss_k = 0;
    bit addr_bad = 0, prev_final = 0, prev_stall = 0;
    logic [PR*32-1:0] prev_data;
    logic [RW-1:0] prev_row;

    always @(negedge clk) if (rst_n) begin
        if (rd_en) begin
            if (int'(j_addr) != iss_k || int'(x_addr) != iss_k % CT || int'(z_addr) != iss_k / CT)
                addr_bad = 1;
            iss_k++;
        end
        if (prev_stall)  // R7
            chk(out_valid && out_data == prev_data && out_row == prev_row, "R7 hold",
                longint'(out_row), longint'(prev_row));
        if (done || prev_final) begin
            chk(done == prev_final, "R8 done timing", longint'(done), longint'(prev_final));
            if (done) chk(!busy, "R8 busy low with done", longint'(busy), 0);
        end
        if (done) done_cnt++;
        prev_final = 0;
        if (out_valid && out_ready) begin
            if (cap_n < 16) begin
                cap_data[cap_n] = out_data;
                cap_row[cap_n]  = int'(out_row);
            end
            cap_n++;
            prev_final = (int'(out_row) == (BLK * RT + RT - 1) * PR);
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_row   = out_row;
    end

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    task automatic load_mems();
        for (int rt = 0; rt < RT; rt++) begin
            for (int ct = 0; ct < CT; ct++)
                for (int r = 0; r < PR; r++)
                    for (int c = 0; c < PC; c++)
                        jmem[rt*CT+ct][(r*PC+c)*16 +: 16] = 16'(jm[rt*PR+r][ct*PC+c]);
            for (int r = 0; r < PR; r++) zmem[rt][r*32 +: 32] = 32'(zm[rt*PR+r]);
        end
        for (int ct = 0; ct < CT; ct++)
            for (int c = 0; c < PC; c++) xmem[ct][c*16 +: 16] = 16'(xm[ct*PC+c]);
    endtask

    task automatic fill(input int lo, input int hi, input int zlo, input int zhi);
        for (int i = 0; i < NB; i++) begin
            for (int j = 0; j < N; j++) jm[i][j] = lo + int'($urandom_range(hi - lo));
            zm[i] = zlo + int'($urandom_range(zhi - zlo));
        end
        for (int j = 0; j < N; j++) xm[j] = lo + int'($urandom_range(hi - lo));
    endtask

    // mode 0: ready high, 1: irregular ready, 2: irregular ready plus start while busy
    task automatic run_pass(input int mode, input string req);
        int cyc = 0;
        bit [7:0] lfsr = 8'hA5;
        load_mems();
        cap_n = 0; done_cnt = 0; iss_k = 0; addr_bad = 0;
        @(posedge clk); #1 start = 1; out_ready = 1;
        @(posedge clk); #1 start = 0;
        while (done_cnt == 0 && cyc < 2000) begin
            if (mode != 0) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                out_ready = lfsr[0] & lfsr[2];
            end
            if (mode == 2) start = (cyc == 2 || cyc == 5);
            @(posedge clk); #1;
            cyc++;
        end
        start = 0; out_ready = 1;
        chk(cyc < 2000, {req, " watchdog"}, cyc, 2000);
        repeat (6) @(posedge clk);
        #1;
        chk(cap_n == RT, "R10 result count", cap_n, RT);
        chk(iss_k == DEPTH, "R10 read count", iss_k, DEPTH);
        chk(done_cnt == 1, "R8 done count", done_cnt, 1);
        chk(!addr_bad, "R4 address order", longint'(addr_bad), 0);
        for (int rt = 0; rt < RT && rt < cap_n; rt++) begin
            chk(cap_row[rt] == (BLK * RT + rt) * PR, "R4 row index", cap_row[rt], (BLK * RT + rt) * PR);
            for (int r = 0; r < PR; r++) begin
                longint acc = 0, got;
                for (int ct = 0; ct < CT; ct++) begin
                    longint s = acc;
                    for (int c = 0; c < PC; c++) s += longint'(jm[rt*PR+r][ct*PC+c]) * xm[ct*PC+c];
                    if (ct == CT - 1) s += zm[rt*PR+r];
                    acc = sat32(s);
                end
                got = longint'($signed(cap_data[rt][r*32 +: 32]));
                chk(got == acc, req, got, acc);
            end
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !out_valid && !rd_en, "R1 reset idle",
            longint'({busy, done, out_valid, rd_en}), 0);
    endtask

    task automatic t_basic();
        fill(-300, 300, -5000, 5000);
        run_pass(0, "R2 field value");
    endtask

    task automatic t_bias();
        fill(0, 0, -90000, 90000);
        run_pass(0, "R5 bias only");
    endtask

    task automatic t_clear();
        fill(-32768, 32767, -100, 100);
        run_pass(0, "R6 first pass");
        fill(-50, 50, -10, 10);
        run_pass(0, "R6 cleared between passes");
    endtask

    task automatic t_backpressure();
        fill(-2000, 2000, -1000, 1000);
        run_pass(1, "R7 backpressure");
    endtask

    task automatic t_saturate();
        fill(-32768, -32768, 0, 0);
        for (int j = 0; j < N; j++) xm[j] = -32768;
        run_pass(0, "R3 positive clamp");
        for (int j = 0; j < N; j++) xm[j] = 32767;
        for (int i = 0; i < NB; i++) zm[i] = -7;
        run_pass(1, "R3 negative clamp");
    endtask

    task automatic t_start_busy();
        fill(-1000, 1000, -300, 300);
        run_pass(2, "R9 start while busy");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_bias();
        t_clear();
        t_backpressure();
        t_saturate();
        t_start_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule